// File: doc/BRIEF.md
# Big-integer multiply-accumulate row engine

This block performs one row of schoolbook multi-word multiplication and folds that row into a running sum. Software first loads a vector of N operand limbs and a result vector of N+1 limbs through a limb-wide load port. A single-cycle start pulse then latches a 64-bit scalar multiplier. The engine walks the operand limbs from index 0 upward, one per cycle. Each limb is multiplied by the scalar and the 64-bit high half of the previous step is added in. The low half of that sum is stored as a row limb, and the high half is carried to the next limb.

Because a 64x64 product plus two 64-bit addends always fits in 128 bits, the multiply chain needs no separate carry flag. After the last operand limb, the remaining high half is stored as row limb N. A second pass then adds the N+1 row limbs into the result vector, again in ascending order and one limb per cycle, using a one-bit carry flag that starts at zero. The final carry is presented on a status output, and done pulses once the result vector is complete.

Repeated starts with different multipliers (and shifted result windows managed by software) build a full multi-word product in the manner of the classical schoolbook algorithm.

Top module: `bigmac_row_engine`

## Requirements
- R1: After reset busy, done and carry_out are 0, and every operand, row and result limb reads as zero.
- R2: When idle, ld_en with ld_sel=0 writes ld_data to operand limb ld_idx (indices 0..N-1) and with ld_sel=1 to result limb ld_idx (indices 0..N). rd_sel selects the combinational read: 0 operand, 1 row, 2 result, 3 always zero. An operand index of N or more reads as zero.
- R3: Row limb i equals the low 64 bits of a_i*m + c_i, where c_0 = 0 and c_(i+1) is the high 64 bits of that sum. Row limb N equals c_N, so the row read as one integer equals A*m exactly.
- R4: With all-ones operands and multiplier the chain completes without loss: the row equals (2^(64N)-1)*(2^64-1).
- R5: On completion the result vector equals (old result + row) mod 2^(64(N+1)), with the carry flag cleared before the first limb, and carry_out equals the carry out of limb N.
- R6: done is high for exactly one cycle, 2N+2 clock edges after the edge that samples start. busy is high from the cycle after that edge through the done cycle.
- R7: A start pulse while busy is ignored: the run keeps its timing and its results.
- R8: Loads while busy are ignored: operand and result limbs keep the values the engine gives them.
- R9: The multiplier is latched at start, and changes on mult during a run have no effect.
- R10: carry_out reads 0 once a run starts and keeps the final carry after done until the next start.
- R11: Back-to-back runs accumulate: a second run adds its row to the result left by the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start a row; sampled only when idle |
| mult | input | 64 | Scalar multiplier, latched at start |
| ld_en | input | 1 | Load strobe, honoured only when idle |
| ld_sel | input | 1 | Load target: 0 operand, 1 result |
| ld_idx | input | $clog2(N+1) | Limb index for load |
| ld_data | input | 64 | Limb value for load |
| rd_sel | input | 2 | Read source: 0 operand, 1 row, 2 result, 3 zero |
| rd_idx | input | $clog2(N+1) | Limb index for read |
| rd_data | output | 64 | Selected limb |
| busy | output | 1 | Engine running |
| done | output | 1 | One-cycle completion pulse |
| carry_out | output | 1 | Final carry from the result addition |

## Verification
The bench builds the engine with N=4 rather than the default 8. This keeps the wide reference integers at 256 and 320 bits, so each row and each sum can be computed directly as a single wide multiply and add. The run latency shrinks to 10 edges, which makes an exact cycle count per run practical. N=4 still spans every boundary that matters: the first limb with its zero carry, interior limbs, the extra top limb N, and a carry-out from the top of the result vector.

// File: rtl/bigmac_pkg.sv
package bigmac_pkg;

  localparam int unsigned LIMB_W = 64;

  typedef logic [LIMB_W-1:0] limb_t;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_MUL  = 3'd1,
    PH_TAIL = 3'd2,
    PH_ADD  = 3'd3,
    PH_FIN  = 3'd4
  } phase_e;

  // a*b + c over a double-width limb; never exceeds 2^128 - 1
  function automatic logic [2*LIMB_W-1:0] mac_wide(input limb_t a, input limb_t b,
                                                   input limb_t c);
    logic [2*LIMB_W-1:0] p;
    p = {{LIMB_W{1'b0}}, a} * {{LIMB_W{1'b0}}, b};
    return p + {{LIMB_W{1'b0}}, c};
  endfunction

  // a + b + ci with the carry out in the top bit
  function automatic logic [LIMB_W:0] adc_wide(input limb_t a, input limb_t b,
                                               input logic ci);
    return {1'b0, a} + {1'b0, b} + {{LIMB_W{1'b0}}, ci};
  endfunction

endpackage

// File: rtl/bigmac_limb_bank.sv
module bigmac_limb_bank
  import bigmac_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_we,
  input  logic [IDX_W-1:0] ext_idx,
  input  limb_t            ext_data,
  input  logic             int_we,
  input  logic [IDX_W-1:0] int_idx,
  input  limb_t            int_data,
  input  logic [IDX_W-1:0] rd_idx,
  output limb_t            rd_data,
  input  logic [IDX_W-1:0] rd2_idx,
  output limb_t            rd2_data
);

  limb_t mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic hit_int, hit_ext;
    assign hit_int = int_we && (int_idx == IDX_W'(e));
    assign hit_ext = ext_we && (ext_idx == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem[e] <= '0;
      else if (hit_int) mem[e] <= int_data;
      else if (hit_ext) mem[e] <= ext_data;
    end
  end

  always_comb begin
    rd_data  = '0;
    rd2_data = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (rd_idx  == IDX_W'(e)) rd_data  = mem[e];
      if (rd2_idx == IDX_W'(e)) rd2_data = mem[e];
    end
  end

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_we && int_we)); // R8

endmodule

// File: rtl/bigmac_mac_unit.sv
module bigmac_mac_unit
  import bigmac_pkg::*;
(
  input  limb_t a,
  input  limb_t b,
  input  limb_t c,
  output limb_t lo,
  output limb_t hi
);

  logic [2*LIMB_W-1:0] full;

  always_comb begin
    full = mac_wide(a, b, c);
    lo   = full[LIMB_W-1:0];
    hi   = full[2*LIMB_W-1:LIMB_W];
  end

endmodule

// File: rtl/bigmac_adc_unit.sv
module bigmac_adc_unit
  import bigmac_pkg::*;
(
  input  limb_t a,
  input  limb_t b,
  input  logic  ci,
  output limb_t sum,
  output logic  co
);

  logic [LIMB_W:0] full;

  always_comb begin
    full = adc_wide(a, b, ci);
    sum  = full[LIMB_W-1:0];
    co   = full[LIMB_W];
  end

endmodule

// File: rtl/bigmac_ctrl.sv
module bigmac_ctrl
  import bigmac_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output phase_e           phase,
  output logic [IDX_W-1:0] idx,
  output logic             start_fire,
  output logic             mul_we,
  output logic             tail_we,
  output logic             add_we,
  output logic             busy,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_MUL = IDX_W'(N - 1);
  localparam logic [IDX_W-1:0] LAST_ADD = IDX_W'(N);

  phase_e           phase_d;
  logic [IDX_W-1:0] idx_d;

  assign start_fire = start && (phase == PH_IDLE);
  assign mul_we     = (phase == PH_MUL);
  assign tail_we    = (phase == PH_TAIL);
  assign add_we     = (phase == PH_ADD);
  assign busy       = (phase != PH_IDLE);
  assign done       = (phase == PH_FIN);

  always_comb begin
    phase_d = phase;
    idx_d   = idx;
    unique case (phase)
      PH_IDLE: if (start) begin
        phase_d = PH_MUL;
        idx_d   = '0;
      end
      PH_MUL: begin
        if (idx == LAST_MUL) phase_d = PH_TAIL;
        idx_d = idx + 1'b1;
      end
      PH_TAIL: begin
        phase_d = PH_ADD;
        idx_d   = '0;
      end
      PH_ADD: begin
        if (idx == LAST_ADD) phase_d = PH_FIN;
        else                 idx_d   = idx + 1'b1;
      end
      PH_FIN:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      idx   <= '0;
    end else begin
      phase <= phase_d;
      idx   <= idx_d;
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST_ADD); // R3
  AST_TAIL_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    tail_we |-> idx == LAST_ADD); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_ADD_NOT_RESTARTED: assert property (@(posedge clk) disable iff (!rst_n)
    add_we |=> (add_we || done)); // R7

endmodule

// File: rtl/bigmac_row_engine.sv
module bigmac_row_engine
  import bigmac_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [63:0]      mult,
  input  logic             ld_en,
  input  logic             ld_sel,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [63:0]      ld_data,
  input  logic [1:0]       rd_sel,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [63:0]      rd_data,
  output logic             busy,
  output logic             done,
  output logic             carry_out
);

  localparam int unsigned ROW_DEPTH = N + 1;

  phase_e           phase;
  logic [IDX_W-1:0] idx;
  logic             start_fire, mul_we, tail_we, add_we;

  limb_t mult_q, acc_q;
  logic  cf_q;

  limb_t opnd_rd, row_rd, res_rd;
  limb_t opnd_cur, row_cur, res_cur;
  limb_t mac_lo, mac_hi, adc_sum;
  logic  adc_co;

  logic  opnd_ext_we, res_ext_we;
  logic  row_int_we;
  limb_t row_int_data;

  bigmac_ctrl #(.N(N), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .phase(phase), .idx(idx),
    .start_fire(start_fire), .mul_we(mul_we), .tail_we(tail_we),
    .add_we(add_we), .busy(busy), .done(done)
  );

  // external loads only reach the banks while the engine is idle
  assign opnd_ext_we  = ld_en && !busy && !ld_sel;
  assign res_ext_we   = ld_en && !busy &&  ld_sel;
  assign row_int_we   = mul_we || tail_we;
  assign row_int_data = mul_we ? mac_lo : acc_q;

  bigmac_limb_bank #(.DEPTH(N), .IDX_W(IDX_W)) u_opnd (
    .clk(clk), .rst_n(rst_n),
    .ext_we(opnd_ext_we), .ext_idx(ld_idx), .ext_data(ld_data),
    .int_we(1'b0), .int_idx('0), .int_data('0),
    .rd_idx(rd_idx), .rd_data(opnd_rd),
    .rd2_idx(idx), .rd2_data(opnd_cur)
  );

  bigmac_limb_bank #(.DEPTH(ROW_DEPTH), .IDX_W(IDX_W)) u_row (
    .clk(clk), .rst_n(rst_n),
    .ext_we(1'b0), .ext_idx('0), .ext_data('0),
    .int_we(row_int_we), .int_idx(idx), .int_data(row_int_data),
    .rd_idx(rd_idx), .rd_data(row_rd),
    .rd2_idx(idx), .rd2_data(row_cur)
  );

  bigmac_limb_bank #(.DEPTH(ROW_DEPTH), .IDX_W(IDX_W)) u_res (
    .clk(clk), .rst_n(rst_n),
    .ext_we(res_ext_we), .ext_idx(ld_idx), .ext_data(ld_data),
    .int_we(add_we), .int_idx(idx), .int_data(adc_sum),
    .rd_idx(rd_idx), .rd_data(res_rd),
    .rd2_idx(idx), .rd2_data(res_cur)
  );

  bigmac_mac_unit u_mac (
    .a(opnd_cur), .b(mult_q), .c(acc_q), .lo(mac_lo), .hi(mac_hi)
  );

  bigmac_adc_unit u_adc (
    .a(res_cur), .b(row_cur), .ci(cf_q), .sum(adc_sum), .co(adc_co)
  );

  // multiplier latch, multiply carry accumulator, add carry flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q <= '0;
      acc_q  <= '0;
      cf_q   <= 1'b0;
    end else begin
      if (start_fire) begin
        mult_q <= mult;
        acc_q  <= '0;
        cf_q   <= 1'b0;
      end else begin
        if (mul_we)  acc_q <= mac_hi;
        if (tail_we) cf_q  <= 1'b0;
        else if (add_we) cf_q <= adc_co;
      end
    end
  end

  assign carry_out = cf_q;

  always_comb begin
    unique case (rd_sel)
      2'd0:    rd_data = opnd_rd;
      2'd1:    rd_data = row_rd;
      2'd2:    rd_data = res_rd;
      default: rd_data = '0;
    endcase
  end

  AST_MULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mult_q)); // R9
  AST_CARRY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !carry_out); // R10
  AST_FLAG_ZERO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (add_we && idx == '0) |-> !cf_q); // R5
  AST_ACC_ZERO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_we && idx == '0) |-> acc_q == '0); // R3
  AST_DONE_AFTER_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(add_we)); // R6
  AST_CARRY_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && !$past(start)) |-> $stable(carry_out)); // R10

endmodule

// File: tb/bigmac_row_engine_tb.sv
module bigmac_row_engine_tb;

  localparam int N     = 4;
  localparam int IDX_W = $clog2(N + 1);
  localparam int AW    = 64 * N;
  localparam int RW    = 64 * (N + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [63:0]      mult = '0;
  logic             ld_en = 1'b0;
  logic             ld_sel = 1'b0;
  logic [IDX_W-1:0] ld_idx = '0;
  logic [63:0]      ld_data = '0;
  logic [1:0]       rd_sel = '0;
  logic [IDX_W-1:0] rd_idx = '0;
  logic [63:0]      rd_data;
  logic             busy, done, carry_out;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [AW-1:0] a_ref;
  logic [RW-1:0] res_ref;

  always #5 clk = ~clk;

  bigmac_row_engine #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mult(mult),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_idx(ld_idx), .ld_data(ld_data),
    .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data),
    .busy(busy), .done(done), .carry_out(carry_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic read_limb(input logic [1:0] sel, input int i, output logic [63:0] v);
    rd_sel = sel;
    rd_idx = IDX_W'(i);
    #1;
    v = rd_data;
  endtask

  task automatic load_limb(input bit to_res, input int i, input logic [63:0] v);
    ld_en = 1'b1; ld_sel = to_res; ld_idx = IDX_W'(i); ld_data = v;
    @(posedge clk); #1;
    ld_en = 1'b0;
  endtask

  task automatic load_all(input logic [AW-1:0] a, input logic [RW-1:0] r);
    for (int i = 0; i < N; i++)     load_limb(1'b0, i, a[64*i +: 64]);
    for (int i = 0; i <= N; i++)    load_limb(1'b1, i, r[64*i +: 64]);
    a_ref = a;
    res_ref = r;
  endtask

  // starts a row, optionally disturbs it, then checks timing, row, result, carry
  task automatic run_row(input logic [63:0] m, input bit disturb, input string tag);
    logic [RW-1:0]  row_exp;
    logic [RW:0]    sum_exp;
    logic [63:0]    v;
    int             k;
    row_exp = {{64{1'b0}}, a_ref} * {{AW{1'b0}}, m};
    sum_exp = {1'b0, res_ref} + {1'b0, row_exp};
    mult = m;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk(busy == 1'b1, "R6", {tag, " busy after start"}, 64'(busy), 64'd1);
    chk(carry_out == 1'b0, "R10", {tag, " carry cleared at start"}, 64'(carry_out), 64'd0);
    k = 0;
    while (k < 100) begin
      if (disturb && k == 2) begin
        start = 1'b1; mult = ~m;
        ld_en = 1'b1; ld_sel = 1'b0; ld_idx = '0; ld_data = 64'hDEAD_BEEF_0000_0001;
      end
      if (disturb && k == 6) begin
        start = 1'b1; mult = 64'h1234;
        ld_en = 1'b1; ld_sel = 1'b1; ld_idx = IDX_W'(1); ld_data = 64'hFEED_0000_0000_0002;
      end
      @(posedge clk); #1;
      start = 1'b0; ld_en = 1'b0;
      k++;
      if (done) break;
    end
    chk(k == 2 * N + 2, "R6", {tag, " done latency"}, 64'(k), 64'(2 * N + 2));
    chk(busy == 1'b1, "R6", {tag, " busy in done cycle"}, 64'(busy), 64'd1);
    chk(carry_out == sum_exp[RW], "R5", {tag, " carry_out"}, 64'(carry_out), 64'(sum_exp[RW]));
    @(posedge clk); #1;
    chk(done == 1'b0 && busy == 1'b0, "R6", {tag, " done one cycle"}, 64'({done, busy}), 64'd0);
    repeat (2) @(posedge clk);
    #1;
    chk(carry_out == sum_exp[RW], "R10", {tag, " carry held"}, 64'(carry_out), 64'(sum_exp[RW]));
    for (int i = 0; i <= N; i++) begin
      read_limb(2'd1, i, v);
      chk(v == row_exp[64*i +: 64], "R3", $sformatf("%s row limb %0d", tag, i), v, row_exp[64*i +: 64]);
      read_limb(2'd2, i, v);
      chk(v == sum_exp[64*i +: 64], "R5", $sformatf("%s result limb %0d", tag, i), v, sum_exp[64*i +: 64]);
    end
    if (disturb) begin
      read_limb(2'd0, 0, v);
      chk(v == a_ref[63:0], "R8", {tag, " operand untouched"}, v, a_ref[63:0]);
    end
    res_ref = sum_exp[RW-1:0];
  endtask

  task automatic t_reset;
    logic [63:0] v;
    chk(busy == 1'b0 && done == 1'b0 && carry_out == 1'b0, "R1", "status after reset",
        64'({busy, done, carry_out}), 64'd0);
    for (int i = 0; i <= N; i++) begin
      for (int s = 0; s < 3; s++) begin
        read_limb(2'(s), i, v);
        chk(v == '0, "R1", $sformatf("sel %0d limb %0d zero", s, i), v, 64'd0);
      end
    end
  endtask

  task automatic t_load;
    logic [63:0] v;
    load_all({64'h4444, 64'h3333, 64'h2222, 64'h1111},
             {64'h5, 64'h4, 64'h3, 64'h2, 64'h1});
    read_limb(2'd0, 2, v);
    chk(v == 64'h3333, "R2", "operand readback", v, 64'h3333);
    read_limb(2'd2, N, v);
    chk(v == 64'h5, "R2", "result top readback", v, 64'h5);
    read_limb(2'd0, N, v);
    chk(v == '0, "R2", "operand out of range", v, 64'd0);
    read_limb(2'd3, 1, v);
    chk(v == '0, "R2", "sel 3 zero", v, 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_load();
    run_row(64'h0000_0001_0000_0003, 1'b0, "basic");
    load_all({64'h8000_0000_0000_0001, 64'hFFFF_0000_FFFF_0000,
              64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF}, '0);
    run_row(64'hFEDC_BA98_7654_3210, 1'b0, "mixed");
    load_all({AW{1'b1}}, {RW{1'b1}});
    run_row({64{1'b1}}, 1'b0, "R4 allones");
    run_row(64'd0, 1'b0, "zero mult");
    load_all({64'h7, 64'h6, 64'h5, 64'h9}, {64'h0, {4{64'hFFFF_FFFF_FFFF_FFFF}}});
    run_row(64'h2, 1'b0, "R11 first");
    run_row(64'hFFFF_FFFF_0000_0001, 1'b0, "R11 second");
    run_row(64'h0000_00AB_CDEF_0123, 1'b1, "R7 R8 R9 disturb");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule